// File: doc/BRIEF.md
# MIDI UART Host Port

This block connects a host bus to a serial MIDI link that runs as a plain UART. The host sees two byte-wide addresses. Address 0 is the data port: a read takes the oldest received byte and a write queues a byte for transmission. Address 1 returns a status byte on read and accepts a command byte on write. Behind the data port sit a 4-entry transmit queue feeding a serializer and a 4-entry receive queue fed by a deserializer. Both run at the MIDI rate of 31250 baud, derived from the system clock frequency given as a parameter.

The status byte flags conditions in "wait" polarity: a set bit means the host must hold off. An interrupt line stays high while the receive queue holds data, so reading the last queued byte clears it. Two commands act on the port. A reset command flushes both queues and leaves an acknowledge byte in the receive queue. A UART-mode command only leaves the acknowledge byte. Every command byte is echoed in the low status bits.

Top module: `midi_uart_port`

## Requirements
- R1: A read at address 0 returns the oldest byte in the receive queue and removes it; a write at address 0 queues the byte for transmission. A read at address 1 returns status; a write at address 1 is a command.
- R2: Status bit 7 is 1 while the receive queue is empty and 0 while it holds at least one byte.
- R3: Status bit 6 is 1 while the transmit queue holds 4 bytes. A data write made while it is 1 is ignored and never reaches the serial output.
- R4: Status bits 5:0 equal bits 5:0 of the most recent command byte, and are 0 after reset. The status reads 0x80 after reset.
- R5: `irq` is 0 after reset, high while the receive queue holds data, and returns to 0 when a host read at address 0 takes the last byte.
- R6: `txd` idles at 1. Each byte leaves as a start bit of 0, then 8 data bits least significant first, then a stop bit of 1. Each bit lasts CLK_HZ/BAUD clock cycles.
- R7: A frame on `rxd` whose stop bit samples 1 has its 8 data bits, least significant first, stored in the receive queue. A frame whose stop bit samples 0 is discarded.
- R8: Both queues are first-in first-out and hold 4 bytes. A serial byte that completes while the receive queue is full is dropped.
- R9: Command 0xFF empties both queues and leaves exactly one byte, 0xFE, in the receive queue. A byte already being shifted out finishes.
- R10: Command 0x3F adds the byte 0xFE to the receive queue. Any other command except 0xFF only updates the status echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 1 | Register address, 0 data, 1 status/command |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Read data for the addressed register, valid in the strobe cycle |
| irq | output | 1 | Receive-data interrupt, high while bytes are waiting |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The bench fills the transmit queue behind a busy serializer and writes one extra byte. A design that mishandles a full queue either shows the wrong wait flag or sends a sixth byte. It also sends five frames with no reads in between; a receiver that overwrites the head instead of dropping returns the wrong fourth byte. The bench issues a reset command with both queues loaded. A design that forgets one flush would show stale receive data ahead of 0xFE, or would keep transmitting. A frame with a bad stop bit and a command that is neither reset nor UART mode check that nothing is stored. Measuring the start-bit length against the divider exposes a wrong bit period.

// File: rtl/midi_uart_pkg.sv
package midi_uart_pkg;

  localparam logic [7:0] ACK_BYTE  = 8'hFE;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART  = 8'h3F;

  typedef struct packed {
    logic txPush;
    logic txFlush;
    logic rxPop;
    logic rxFlush;
    logic ackPush;
  } midiStrobe_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rxState_t;

endpackage

// File: rtl/midi_uart_fifo.sv
module midi_uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rdPtr, wrPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= push ? AW'(1) : '0;
      count <= push ? CW'(1) : '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (flush && push)  mem[0]     <= pushData;
    else if (doPush)    mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/midi_uart_ctrl.sv
module midi_uart_ctrl
  import midi_uart_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostAddr,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [7:0]  hostWData,
  input  logic        rxEmpty,
  input  logic        txFull,
  input  logic [7:0]  rxHead,
  output midiStrobe_t strobe,
  output logic [7:0]  hostRData
);
  logic [5:0] lastCmd;
  logic       cmdWrite;

  assign cmdWrite = hostWr && hostAddr;

  always_ff @(posedge clk) begin
    if (!rstN)         lastCmd <= '0;
    else if (cmdWrite) lastCmd <= hostWData[5:0];
  end

  always_comb begin
    strobe         = '0;
    strobe.txPush  = hostWr && !hostAddr && !txFull;
    strobe.rxPop   = hostRd && !hostAddr && !rxEmpty;
    strobe.txFlush = cmdWrite && (hostWData == CMD_RESET);
    strobe.rxFlush = cmdWrite && (hostWData == CMD_RESET);
    strobe.ackPush = cmdWrite && ((hostWData == CMD_RESET) || (hostWData == CMD_UART));
  end

  always_comb begin
    if (hostAddr) hostRData = {rxEmpty, txFull, lastCmd};
    else          hostRData = rxEmpty ? 8'h00 : rxHead;
  end

endmodule

// File: rtl/midi_uart_datapath.sv
module midi_uart_datapath
  import midi_uart_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 31_250,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  midiStrobe_t strobe,
  input  logic [7:0]  txData,
  output logic        rxEmpty,
  output logic        txFull,
  output logic [7:0]  rxHead,
  output logic        txd,
  input  logic        rxd
);
  localparam int DIV   = CLK_HZ / BAUD;
  localparam int HALF  = DIV / 2;
  localparam int CW    = $clog2(DIV + 1);
  localparam int FRAME = 10;

  // transmit queue and serializer
  logic [7:0] txHead;
  logic       txEmpty, txLoad, txBusy;
  logic [FRAME-1:0] txShift;
  logic [3:0] txBitsLeft;
  logic [CW-1:0] txCnt;

  assign txLoad = !txBusy && !txEmpty;

  midi_uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush), .push(strobe.txPush),
    .pushData(txData), .pop(txLoad), .head(txHead), .empty(txEmpty), .full(txFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy     <= 1'b0;
      txShift    <= '1;
      txBitsLeft <= '0;
      txCnt      <= '0;
    end else if (!txBusy) begin
      if (!txEmpty) begin
        txBusy     <= 1'b1;
        txShift    <= {1'b1, txHead, 1'b0};
        txBitsLeft <= 4'(FRAME);
        txCnt      <= '0;
      end
    end else if (txCnt == CW'(DIV - 1)) begin
      txCnt      <= '0;
      txShift    <= {1'b1, txShift[FRAME-1:1]};
      txBitsLeft <= txBitsLeft - 1'b1;
      if (txBitsLeft == 4'd1) txBusy <= 1'b0;
    end else begin
      txCnt <= txCnt + 1'b1;
    end
  end

  assign txd = txBusy ? txShift[0] : 1'b1;

  // receive deserializer
  logic rxMeta, rxSync;
  rxState_t rxState;
  logic [CW-1:0] rxCnt;
  logic [2:0] rxBitIdx;
  logic [7:0] rxShift;
  logic rxByteValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState     <= RX_IDLE;
      rxCnt       <= '0;
      rxBitIdx    <= '0;
      rxShift     <= '0;
      rxByteValid <= 1'b0;
    end else begin
      rxByteValid <= 1'b0;
      case (rxState)
        RX_IDLE: begin
          rxCnt <= '0;
          if (!rxSync) rxState <= RX_START;
        end
        RX_START: begin
          if (rxCnt == CW'(HALF - 1)) begin
            rxCnt    <= '0;
            rxBitIdx <= '0;
            rxState  <= rxSync ? RX_IDLE : RX_DATA;
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_DATA: begin
          if (rxCnt == CW'(DIV - 1)) begin
            rxCnt    <= '0;
            rxShift  <= {rxSync, rxShift[7:1]};
            rxBitIdx <= rxBitIdx + 1'b1;
            if (rxBitIdx == 3'd7) rxState <= RX_STOP;
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_STOP: begin
          if (rxCnt == CW'(DIV - 1)) begin
            rxCnt       <= '0;
            rxByteValid <= rxSync;
            rxState     <= RX_WAIT_HIGH;
          end else rxCnt <= rxCnt + 1'b1;
        end
        default: begin
          if (rxSync) rxState <= RX_IDLE;
        end
      endcase
    end
  end

  // receive queue: the acknowledge byte takes the single write port first
  logic       rxPush;
  logic [7:0] rxPushData;
  logic       rxFull;

  assign rxPush     = strobe.ackPush || rxByteValid;
  assign rxPushData = strobe.ackPush ? ACK_BYTE : rxShift;

  midi_uart_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush), .push(rxPush),
    .pushData(rxPushData), .pop(strobe.rxPop), .head(rxHead), .empty(rxEmpty),
    .full(rxFull)
  );

  logic unusedRxFull;
  assign unusedRxFull = rxFull;

endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
  import midi_uart_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 31_250,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWData,
  output logic [7:0] hostRData,
  output logic       irq,
  output logic       txd,
  input  logic       rxd
);
  midiStrobe_t strobe;
  logic        rxEmpty, txFull;
  logic [7:0]  rxHead;

  midi_uart_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWData(hostWData), .rxEmpty(rxEmpty),
    .txFull(txFull), .rxHead(rxHead), .strobe(strobe), .hostRData(hostRData)
  );

  midi_uart_datapath #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(hostWData),
    .rxEmpty(rxEmpty), .txFull(txFull), .rxHead(rxHead), .txd(txd), .rxd(rxd)
  );

  assign irq = !rxEmpty;

endmodule

// File: rtl/midi_uart_port_chk.sv
module midi_uart_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostAddr,
  input logic       hostWr,
  input logic       hostRd,
  input logic [7:0] hostWData,
  input logic [7:0] hostRData,
  input logic       irq,
  input logic       txd
);
  // R5 / R2: interrupt agrees with the empty flag in the status byte
  p_irq_status_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostAddr |-> (irq == !hostRData[7]));

  // R4: status echo follows the command just written
  p_cmd_echo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr) |=> (!hostAddr || hostRData[5:0] == $past(hostWData[5:0])));

  // R10: an acknowledging command leaves data waiting
  p_ack_after_cmd_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr && !hostRd && (hostWData == 8'h3F || hostWData == 8'hFF)) |=> irq);

  // R9: after the reset command the transmit queue has room
  p_flush_room_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr && hostWData == 8'hFF) |=> (!hostAddr || !hostRData[6]));

  // R6: a start bit lasts longer than one clock
  p_start_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txd) |=> !txd);

endmodule

bind midi_uart_port midi_uart_port_chk u_chk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
  .hostRd(hostRd), .hostWData(hostWData), .hostRData(hostRData),
  .irq(irq), .txd(txd)
);

// File: tb/tb_midi_uart_port.sv
module tb_midi_uart_port;
  localparam int CLK_HZ = 500_000;
  localparam int BAUD   = 31_250;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam logic [7:0] VEC [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostAddr = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWData = '0;
  logic [7:0] hostRData;
  logic irq, txd;
  logic rxd = 1'b1;

  int checkCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  midi_uart_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(4)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWData(hostWData), .hostRData(hostRData),
    .irq(irq), .txd(txd), .rxd(rxd)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    #5 d = hostRData;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic sendSerial(input logic [7:0] b, input logic stopBit);
    rxd = 1'b0; waitClk(DIV);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; waitClk(DIV);
    end
    rxd = stopBit; waitClk(DIV);
    rxd = 1'b1; waitClk(DIV);
  endtask

  // waits up to limit cycles for a start bit, then samples mid-bit
  task automatic catchTx(input int limit, output logic [7:0] b, output logic stopBit, output bit seen);
    int n = 0;
    seen = 1'b0; b = '0; stopBit = 1'b0;
    while (txd !== 1'b0 && n < limit) begin
      @(negedge clk); n++;
    end
    if (txd === 1'b0) begin
      seen = 1'b1;
      waitClk(DIV / 2);
      for (int i = 0; i < 8; i++) begin
        waitClk(DIV); b[i] = txd;
      end
      waitClk(DIV); stopBit = txd;
      waitClk(DIV / 2);
    end
  endtask

  logic [7:0] got;
  logic gotStop;
  bit gotSeen;
  logic [7:0] caught [6];
  int lowLen;

  initial begin
    waitClk(150_000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // reset state
    hostRead(1'b1, got);
    chk(got == 8'h80, "R4 R2 reset status", got, 8'h80);
    chk(irq == 1'b0, "R5 reset irq", irq, 0);
    chk(txd == 1'b1, "R6 idle line", txd, 1);

    // table walk: each byte out through txd, then back in through rxd
    for (int v = 0; v < 5; v++) begin
      hostWrite(1'b0, VEC[v]);
      catchTx(100, got, gotStop, gotSeen);
      chk(gotSeen && got == VEC[v] && gotStop, "R1 R6 tx frame", got, VEC[v]);
      sendSerial(VEC[v], 1'b1);
      hostRead(1'b1, got);
      chk(got[7] == 1'b0, "R2 rx ready flag", got[7], 0);
      chk(irq == 1'b1, "R5 irq with data", irq, 1);
      hostRead(1'b0, got);
      chk(got == VEC[v], "R7 R1 rx data", got, VEC[v]);
      waitClk(1);
      chk(irq == 1'b0, "R5 irq cleared by read", irq, 0);
    end

    // bit period: 0xFE gives start bit plus bit0 low, 2*DIV cycles
    hostWrite(1'b0, 8'hFE);
    while (txd !== 1'b0) @(negedge clk);
    lowLen = 0;
    while (txd === 1'b0) begin
      lowLen++; @(negedge clk);
    end
    chk(lowLen == 2 * DIV, "R6 bit period", lowLen, 2 * DIV);
    waitClk(10 * DIV);

    // transmit full: 5 writes (one loads at once), a 6th is ignored
    fork
      begin
        for (int i = 0; i < 5; i++) hostWrite(1'b0, 8'h11 + 8'(i));
        hostRead(1'b1, got);
        chk(got[6] == 1'b1, "R3 tx full flag", got[6], 1);
        hostWrite(1'b0, 8'h66);
      end
      begin
        for (int i = 0; i < 6; i++) begin
          catchTx(400, caught[i], gotStop, gotSeen);
          if (!gotSeen) caught[i] = 8'hEE;
        end
      end
    join
    for (int i = 0; i < 5; i++)
      chk(caught[i] == 8'h11 + 8'(i), "R8 R3 tx order", caught[i], 8'h11 + 8'(i));
    chk(caught[5] == 8'hEE, "R3 write while full ignored", caught[5], 8'hEE);

    // receive overflow: fifth byte dropped
    for (int i = 0; i < 5; i++) sendSerial(8'hA1 + 8'(i), 1'b1);
    for (int i = 0; i < 4; i++) begin
      hostRead(1'b0, got);
      chk(got == 8'hA1 + 8'(i), "R8 rx order", got, 8'hA1 + 8'(i));
    end
    hostRead(1'b1, got);
    chk(got[7] == 1'b1, "R8 fifth rx byte dropped", got[7], 1);

    // framing error discarded
    sendSerial(8'h77, 1'b0);
    waitClk(2 * DIV);
    hostRead(1'b1, got);
    chk(got[7] == 1'b1, "R7 bad stop discarded", got[7], 1);

    // UART-mode command
    hostWrite(1'b1, 8'h3F);
    hostRead(1'b1, got);
    chk(got == 8'h3F, "R10 R4 uart cmd status", got, 8'h3F);
    hostRead(1'b0, got);
    chk(got == 8'hFE, "R10 uart cmd ack", got, 8'hFE);

    // other command: echo only
    hostWrite(1'b1, 8'h12);
    hostRead(1'b1, got);
    chk(got == 8'h92, "R10 R4 plain cmd no ack", got, 8'h92);

    // reset command with both queues loaded
    sendSerial(8'h55, 1'b1);
    for (int i = 0; i < 5; i++) hostWrite(1'b0, 8'h30 + 8'(i));
    hostWrite(1'b1, 8'hFF);
    hostRead(1'b1, got);
    chk(got == 8'h3F, "R9 status after reset cmd", got, 8'h3F);
    hostRead(1'b0, got);
    chk(got == 8'hFE, "R9 only ack remains", got, 8'hFE);
    hostRead(1'b1, got);
    chk(got[7] == 1'b1, "R9 rx empty after ack", got[7], 1);
    waitClk(12 * DIV);
    catchTx(20 * DIV, got, gotStop, gotSeen);
    chk(!gotSeen, "R9 tx queue flushed", gotSeen, 0);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule